// File: doc/BRIEF.md
# Serial Flash Program-Mode Shift Engine

This block sends a short byte sequence built by software onto a single-lane SPI bus and keeps the bytes that come back. Software fills up to six transmit byte registers, writes a transfer length in bits, and sets the start bit in the command register. The engine pulls chip select low and runs SPI mode 0 for exactly that many bits. It shifts every sampled MISO bit into a ten-byte receive bank. When the last bit and a one-period trailing gap are done, it releases chip select and clears the start bit. Software polls the start bit to see when the transfer has finished.

The transmit bank is sent from the highest index down to the lowest. The receive bank is a single long shift chain, so the newest byte is always at index 0 and earlier bytes move to higher indices. This arrangement suits command, address and dummy bytes followed by a few data bytes. One such opcode-plus-data sequence fits in a single transaction of at most six bytes.

Top module: `prog_shift_engine`

## Requirements
- R1: After reset, cs_n is 1, sck is 0 and mosi is 0. The command, count, all six transmit bytes and all ten receive bytes read 0.
- R2: Register addresses are: command at 0x00 (start is bit 2, other bits read 0), bit count at 0x01, transmit byte i at 0x08+i (i = 0..5), receive byte j at 0x10+j (j = 0..9). The command, count and transmit registers read back the value written while the engine is idle.
- R3: Bits go out MSB first. Transmit byte 5 is sent first, then byte 4 and so on down to byte 0. A transmit byte never written since reset is sent as zero.
- R4: The count register gives the length in bits, and exactly that many SCK pulses are produced. Counts above 48 are treated as 48. Counts that are not a multiple of 8 are allowed.
- R5: SPI mode 0: sck idles low, mosi only changes while sck is low, and miso is sampled at each rising sck edge.
- R6: cs_n falls first. The first sck rising edge comes HALF_CYC clock cycles after cs_n falls, sck never goes high while cs_n is high, and cs_n rises exactly 2*HALF_CYC clock cycles (one SCK period) after the last sck falling edge.
- R7: Each sampled bit enters bit 0 of receive byte 0, and all held bits move up by one across the 80-bit bank. Contents are kept between transactions. After an N-byte transfer, the first byte received is at index N-1 and the last is at index 0.
- R8: The start bit reads 1 for the whole transaction. It clears in the same clock edge at which cs_n rises. While it reads 0, cs_n is 1 and sck is 0.
- R9: Starting with a count of 0 clears the start bit on the next clock edge, with no cs_n or sck activity.
- R10: While the start bit is 1, writes to the command, count and transmit registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| sck | output | 1 | SPI serial clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
Most internal faults show up on the bus within one transaction. A bit counter that is off by one changes the number of SCK pulses. A transmit shifter with the wrong load order changes the first mosi byte. A misplaced capture edge shifts every byte of the receive bank by one bit. A slow or early sequencer tail moves the cs_n release away from its fixed 2*HALF_CYC distance after the last falling edge. A stuck start flag never reads 0 when polled, so the poll limit exposes it.

// File: rtl/prog_eng_pkg.sv
package prog_eng_pkg;

  localparam int ADDR_W      = 5;
  localparam int ADR_CMD     = 0;
  localparam int ADR_CNT     = 1;
  localparam int ADR_TX_BASE = 8;
  localparam int ADR_RX_BASE = 16;
  localparam int START_BIT   = 2;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LOW  = 2'd1,
    SQ_HIGH = 2'd2,
    SQ_TAIL = 2'd3
  } seq_state_e;

endpackage

// File: rtl/prog_eng_regs.sv
module prog_eng_regs
  import prog_eng_pkg::*;
#(
  parameter int TX_BYTES = 6,
  parameter int RX_BYTES = 10,
  parameter int CNT_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [7:0]              wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [7:0]              rd_data,
  input  logic [RX_BYTES*8-1:0]   rx_bank,
  input  logic                    done,
  output logic                    busy,
  output logic [CNT_W-1:0]        bit_cnt,
  output logic [TX_BYTES*8-1:0]   tx_flat
);

  logic [7:0]       tx_q [TX_BYTES];
  logic [7:0]       tx_d [TX_BYTES];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start_q, start_d;
  logic             wr_ok;

  assign wr_ok = wr_en && !start_q;

  // next state
  always_comb begin
    cnt_d   = cnt_q;
    start_d = start_q;
    for (int i = 0; i < TX_BYTES; i++) tx_d[i] = tx_q[i];
    if (done) start_d = 1'b0;
    if (wr_ok) begin
      if (wr_addr == ADDR_W'(ADR_CMD) && wr_data[START_BIT]) start_d = 1'b1;
      if (wr_addr == ADDR_W'(ADR_CNT)) cnt_d = CNT_W'(wr_data);
      for (int i = 0; i < TX_BYTES; i++)
        if (wr_addr == ADDR_W'(ADR_TX_BASE + i)) tx_d[i] = wr_data;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      start_q <= 1'b0;
      for (int i = 0; i < TX_BYTES; i++) tx_q[i] <= '0;
    end else begin
      cnt_q   <= cnt_d;
      start_q <= start_d;
      for (int i = 0; i < TX_BYTES; i++) tx_q[i] <= tx_d[i];
    end
  end

  // flatten: byte TX_BYTES-1 lands in the top bits and is sent first
  for (genvar g = 0; g < TX_BYTES; g++) begin : g_flat
    assign tx_flat[8*g +: 8] = tx_q[g];
  end

  assign busy    = start_q;
  assign bit_cnt = cnt_q;

  // read mux
  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(ADR_CMD)) rd_data[START_BIT] = start_q;
    if (rd_addr == ADDR_W'(ADR_CNT)) rd_data = 8'(cnt_q);
    for (int i = 0; i < TX_BYTES; i++)
      if (rd_addr == ADDR_W'(ADR_TX_BASE + i)) rd_data = tx_q[i];
    for (int j = 0; j < RX_BYTES; j++)
      if (rd_addr == ADDR_W'(ADR_RX_BASE + j)) rd_data = rx_bank[8*j +: 8];
  end

  AST_CNT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    start_q && wr_en && wr_addr == ADDR_W'(ADR_CNT) |=> $stable(cnt_q)); // R10
  AST_TX0_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    start_q && wr_en && wr_addr == ADDR_W'(ADR_TX_BASE) |=> $stable(tx_q[0])); // R10

endmodule

// File: rtl/prog_eng_seq.sv
module prog_eng_seq
  import prog_eng_pkg::*;
#(
  parameter int TX_BITS  = 48,
  parameter int CNT_W    = 8,
  parameter int HALF_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] bit_cnt,
  output logic             sck,
  output logic             cs_n,
  output logic             load,
  output logic             shift,
  output logic             capture,
  output logic             done
);

  localparam int BITS_W = $clog2(TX_BITS + 1);
  localparam int PH_W   = $clog2(2 * HALF_CYC + 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF_CYC - 1);
  localparam logic [PH_W-1:0] PH_FULL = PH_W'(2 * HALF_CYC - 1);

  seq_state_e        state_q, state_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic [BITS_W-1:0] left_q, left_d;
  logic              sck_q, sck_d;
  logic              cs_n_q, cs_n_d;
  logic [BITS_W-1:0] n_eff;

  assign n_eff = (bit_cnt > CNT_W'(TX_BITS)) ? BITS_W'(TX_BITS) : BITS_W'(bit_cnt);

  // next state
  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    left_d  = left_q;
    sck_d   = sck_q;
    cs_n_d  = cs_n_q;
    load    = 1'b0;
    shift   = 1'b0;
    capture = 1'b0;
    done    = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start) begin
          if (n_eff == '0) begin
            done = 1'b1;
          end else begin
            load    = 1'b1;
            cs_n_d  = 1'b0;
            left_d  = n_eff;
            ph_d    = '0;
            state_d = SQ_LOW;
          end
        end
      end
      SQ_LOW: begin
        if (ph_q == PH_HALF) begin
          capture = 1'b1;
          sck_d   = 1'b1;
          ph_d    = '0;
          state_d = SQ_HIGH;
        end else begin
          ph_d = ph_q + 1'b1;
        end
      end
      SQ_HIGH: begin
        if (ph_q == PH_HALF) begin
          sck_d = 1'b0;
          ph_d  = '0;
          if (left_q == BITS_W'(1)) begin
            left_d  = '0;
            state_d = SQ_TAIL;
          end else begin
            left_d  = left_q - 1'b1;
            shift   = 1'b1;
            state_d = SQ_LOW;
          end
        end else begin
          ph_d = ph_q + 1'b1;
        end
      end
      SQ_TAIL: begin
        if (ph_q == PH_FULL) begin
          cs_n_d  = 1'b1;
          done    = 1'b1;
          ph_d    = '0;
          state_d = SQ_IDLE;
        end else begin
          ph_d = ph_q + 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      ph_q    <= '0;
      left_q  <= '0;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      left_q  <= left_d;
      sck_q   <= sck_d;
      cs_n_q  <= cs_n_d;
    end
  end

  assign sck  = sck_q;
  assign cs_n = cs_n_q;

  AST_SCK_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |-> !cs_n_q); // R6
  AST_LEFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= BITS_W'(TX_BITS)); // R4
  AST_CS_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |-> !$past(sck_q)); // R6

endmodule

// File: rtl/prog_eng_shift.sv
module prog_eng_shift #(
  parameter int TX_BITS = 48,
  parameter int RX_BITS = 80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               shift,
  input  logic               capture,
  input  logic [TX_BITS-1:0] tx_flat,
  input  logic               miso,
  output logic               mosi,
  output logic [RX_BITS-1:0] rx_bank
);

  logic [TX_BITS-1:0] tx_q, tx_d;
  logic [RX_BITS-1:0] rx_q, rx_d;

  // next state
  always_comb begin
    tx_d = tx_q;
    rx_d = rx_q;
    if (load)         tx_d = tx_flat;
    else if (shift)   tx_d = {tx_q[TX_BITS-2:0], 1'b0};
    if (capture)      rx_d = {rx_q[RX_BITS-2:0], miso};
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign mosi    = tx_q[TX_BITS-1];
  assign rx_bank = rx_q;

  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load, shift, capture})); // R5

endmodule

// File: rtl/prog_shift_engine.sv
module prog_shift_engine
  import prog_eng_pkg::*;
#(
  parameter int TX_BYTES = 6,
  parameter int RX_BYTES = 10,
  parameter int CNT_W    = 8,
  parameter int HALF_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [4:0]  rd_addr,
  output logic [7:0]  rd_data,
  output logic        sck,
  output logic        cs_n,
  output logic        mosi,
  input  logic        miso
);

  localparam int TX_BITS = TX_BYTES * 8;
  localparam int RX_BITS = RX_BYTES * 8;

  logic                rst_meta_q, rst_sync_q;
  logic                busy, done, load, shift, capture;
  logic [CNT_W-1:0]    bit_cnt;
  logic [TX_BITS-1:0]  tx_flat;
  logic [RX_BITS-1:0]  rx_bank;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  prog_eng_regs #(
    .TX_BYTES (TX_BYTES),
    .RX_BYTES (RX_BYTES),
    .CNT_W    (CNT_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .rx_bank (rx_bank),
    .done    (done),
    .busy    (busy),
    .bit_cnt (bit_cnt),
    .tx_flat (tx_flat)
  );

  prog_eng_seq #(
    .TX_BITS  (TX_BITS),
    .CNT_W    (CNT_W),
    .HALF_CYC (HALF_CYC)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .start   (busy),
    .bit_cnt (bit_cnt),
    .sck     (sck),
    .cs_n    (cs_n),
    .load    (load),
    .shift   (shift),
    .capture (capture),
    .done    (done)
  );

  prog_eng_shift #(
    .TX_BITS (TX_BITS),
    .RX_BITS (RX_BITS)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .load    (load),
    .shift   (shift),
    .capture (capture),
    .tx_flat (tx_flat),
    .miso    (miso),
    .mosi    (mosi),
    .rx_bank (rx_bank)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !busy |-> cs_n && !sck); // R8
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_q)
    sck && $past(sck) |-> $stable(mosi)); // R5
  AST_ZERO_DONE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(busy) && bit_cnt == '0 |=> !busy && cs_n); // R9

endmodule

// File: tb/prog_shift_engine_tb.sv
module prog_shift_engine_tb;

  localparam int HALF = 2;
  localparam time TCK = 8ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       sck, cs_n, mosi;
  logic       miso = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #(TCK/2) clk = ~clk;

  prog_shift_engine #(.HALF_CYC(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // flash-side model
  logic [47:0] slv_resp = '0;
  int          slv_k = 0;
  logic [47:0] mosi_log = '0;
  int          sck_cnt = 0;
  int          cs_falls = 0;
  logic        first_rise = 1'b0;
  time         t_cs_fall = 0, t_last_fall = 0;
  logic        mosi_at_rise = 1'b0;

  always @(negedge cs_n) begin
    slv_k = 0;
    miso = slv_resp[47];
    t_cs_fall = $time;
    first_rise = 1'b1;
    cs_falls++;
  end
  always @(negedge sck) begin
    t_last_fall = $time;
    slv_k++;
    if (slv_k < 48) miso = slv_resp[47 - slv_k];
  end
  always @(posedge sck) begin
    mosi_log = {mosi_log[46:0], mosi};
    mosi_at_rise = mosi;
    sck_cnt++;
    if (first_rise) begin
      first_rise = 1'b0;
      chk(($time - t_cs_fall) == HALF*TCK, "R6 first sck rise delay",
          80'(($time - t_cs_fall)/TCK), 80'(HALF));
    end
  end
  always @(posedge cs_n) begin
    if (rst_n)
      chk(($time - t_last_fall) == 2*HALF*TCK, "R6 cs_n release after last fall",
          80'(($time - t_last_fall)/TCK), 80'(2*HALF));
  end
  int mosi_viol = 0;
  int sck_viol = 0;
  always @(negedge clk) begin
    if (sck === 1'b1 && mosi !== mosi_at_rise) mosi_viol++;
    if (sck === 1'b1 && cs_n === 1'b1) sck_viol++;
  end

  // register access
  logic [7:0]  tx_m [6];
  logic [7:0]  cnt_m = '0;
  logic [79:0] rx_m = '0;

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask
  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask
  task automatic wr_tx(input int i, input logic [7:0] d);
    wr(5'(8 + i), d);
    tx_m[i] = d;
  endtask

  function automatic logic [47:0] tx_cat();
    logic [47:0] v;
    for (int i = 0; i < 6; i++) v[8*i +: 8] = tx_m[i];
    return v;
  endfunction
  function automatic int eff_bits(input logic [7:0] c);
    return (c > 8'd48) ? 48 : int'(c);
  endfunction

  task automatic launch(input logic [7:0] cnt, input logic [47:0] resp);
    wr(5'd1, cnt);
    cnt_m = cnt;
    slv_resp = resp;
    mosi_log = '0;
    sck_cnt = 0;
    cs_falls = 0;
    wr(5'd0, 8'h04);
  endtask

  task automatic finish(input string tag, input logic [47:0] resp, output int polls);
    logic [7:0] d;
    int n;
    logic [47:0] exp_mosi;
    logic [79:0] got_rx;
    polls = 0;
    do begin
      rd(5'd0, d);
      polls++;
      if (d[2]) @(negedge clk);
    end while (d[2] && polls < 2000);
    chk(d[2] == 1'b0, {tag, " R8 start bit clears"}, 80'(d), 80'(0));
    chk(cs_n === 1'b1, {tag, " R8 cs_n high once start clears"}, 80'(cs_n), 80'(1));
    n = eff_bits(cnt_m);
    exp_mosi = tx_cat() >> (48 - n);
    chk(sck_cnt == n, {tag, " R4 sck pulse count"}, 80'(sck_cnt), 80'(n));
    chk(mosi_log == exp_mosi, {tag, " R3 mosi stream"}, 80'(mosi_log), 80'(exp_mosi));
    rx_m = (rx_m << n) | (80'(resp) >> (48 - n));
    for (int j = 0; j < 10; j++) begin
      rd(5'(16 + j), d);
      got_rx[8*j +: 8] = d;
    end
    chk(got_rx == rx_m, {tag, " R7 receive bank"}, got_rx, rx_m);
  endtask

  initial begin
    #(TCK * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0]  d;
    int          polls;
    logic [47:0] r;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 6; i++) tx_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(cs_n === 1'b1 && sck === 1'b0 && mosi === 1'b0, "R1 bus idle after reset",
        80'({cs_n, sck, mosi}), 80'(3'b100));
    for (int a = 0; a < 32; a++) begin
      if (a < 2 || (a >= 8 && a < 14) || (a >= 16 && a < 26)) begin
        rd(5'(a), d);
        chk(d == 8'h00, $sformatf("R1 reg 0x%0h zero after reset", a), 80'(d), 80'(0));
      end
    end

    // R3 unwritten bytes shift out as zero
    wr_tx(5, 8'hA5);
    r = 48'hC3_5A_0F_F0_96_69;
    launch(8'd48, r);
    finish("partial-tx", r, polls);

    // R2 readback
    wr(5'd1, 8'h2D); cnt_m = 8'h2D;
    rd(5'd1, d); chk(d == 8'h2D, "R2 count readback", 80'(d), 80'h2D);
    for (int i = 0; i < 6; i++) begin
      logic [7:0] v;
      v = 8'($urandom);
      wr_tx(i, v);
      rd(5'(8 + i), d);
      chk(d == v, $sformatf("R2 tx byte %0d readback", i), 80'(d), 80'(v));
    end

    // R9 zero count
    r = 48'hFFFF_FFFF_FFFF;
    launch(8'd0, r);
    rd(5'd0, d);
    chk(d[2] == 1'b1, "R9 start visible one cycle", 80'(d), 80'h04);
    @(negedge clk);
    rd(5'd0, d);
    chk(d[2] == 1'b0, "R9 zero count completes", 80'(d), 80'(0));
    chk(sck_cnt == 0 && cs_falls == 0, "R9 no bus activity",
        80'({sck_cnt[15:0], cs_falls[15:0]}), 80'(0));

    // R4 clamp above 48 bits
    r = 48'h1234_5678_9ABC;
    launch(8'd60, r);
    finish("clamp60", r, polls);

    // R4 length not a multiple of 8
    r = 48'hBEEF_0000_0000;
    launch(8'd13, r);
    finish("bits13", r, polls);

    // R10 writes ignored while busy
    r = 48'h0F0F_0F0F_0F0F;
    launch(8'd48, r);
    repeat (5) @(negedge clk);
    wr(5'd8, ~tx_m[0]);
    wr(5'd1, 8'd3);
    wr(5'd0, 8'h04);
    finish("busy", r, polls);
    rd(5'd8, d);
    chk(d == tx_m[0], "R10 tx byte unchanged by busy write", 80'(d), 80'(tx_m[0]));
    rd(5'd1, d);
    chk(d == 8'd48, "R10 count unchanged by busy write", 80'(d), 80'd48);

    // random transactions
    for (int t = 0; t < 24; t++) begin
      logic [7:0] c;
      for (int i = 0; i < 6; i++) wr_tx(i, 8'($urandom));
      c = (t % 4 == 0) ? 8'(8 * (1 + $urandom_range(0, 5))) : 8'($urandom_range(1, 56));
      r = {16'($urandom), 32'($urandom)};
      launch(c, r);
      finish($sformatf("rand%0d", t), r, polls);
    end

    chk(mosi_viol == 0, "R5 mosi stable while sck high", 80'(mosi_viol), 80'(0));
    chk(sck_viol == 0, "R6 sck only inside cs_n low", 80'(sck_viol), 80'(0));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule